// File: doc/BRIEF.md
# Constrained Power-of-Two Clock Divider Bank

The block keeps one 16-bit control word that sets six clock domains. The domains are peripheral, display (LCD), CPU, DSP, DSP memory-management unit and traffic controller. Each domain has a 2-bit exponent, and the domain runs at the master clock divided by 2^exponent. For each domain the block drives a clock-enable strobe. The strobe goes high once in every 2^exponent master cycles. All strobes come from one shared free-running 3-bit counter.

The block never stores a word exactly as software writes it. Each write first passes through a fixed chain of clamps, so the stored exponents always keep the required frequency ordering between domains. A second port takes a request made in rates. It gives a master rate, a target rate and a domain index, and it either adjusts that domain's field or only reports the exponent that would be used. A variant parameter forces bit 13 of the stored word high.

Top module: `clkdiv_bank`

## Requirements
- R1: Field layout is peripheral [1:0], LCD [3:2], CPU [5:4], DSP [7:6], traffic controller [9:8], DSP-MMU [11:10]. Once an exponent e is active, its domain's strobe is high in exactly one of every 2^e consecutive cycles (ratios 1, 2, 4, 8).
- R2: Every stored value has its DSP-MMU exponent no lower than the DSP exponent and no higher than the DSP exponent plus one. The stored value is clamped to that range first.
- R3: Next, the traffic-controller exponent is raised to the CPU exponent if it is lower. After that, it is raised to the clamped DSP-MMU exponent if it is lower.
- R4: Last, the LCD exponent and the peripheral exponent are each raised to the resulting traffic-controller exponent if they are lower.
- R5: Bits [15:12] of a written word are stored unchanged. The six fields are rebuilt from the clamped exponents, and the stored word is visible on the control output in the cycle after the write.
- R6: With FORCE_B13 = 1, bit 13 of the stored word is 1 after reset and after every write or set request.
- R7: A set request (round flag 0) picks the smallest e in 0..3 for which floor(master / 2^e) <= target. It inserts e into the field of domain index req_dom (0 peripheral, 1 LCD, 2 CPU, 3 DSP, 4 traffic controller, 5 DSP-MMU) and stores the result after the R2–R4 clamps. The response comes one cycle later with rsp_err = 0 and rsp_exp = e.
- R8: A set request for which no e up to 3 meets the target returns rsp_err = 1 and rsp_exp = 3, and the stored word stays unchanged.
- R9: A round request (round flag 1) returns the same e as R7, or 3 when the target cannot be reached. It never reports an error for a valid domain, and it never changes the stored word.
- R10: A domain's new exponent becomes active only when the shared counter wraps from 7 to 0. Strobes are phase aligned, so whenever the LCD strobe is high, the traffic-controller strobe is high too.
- R11: After reset, the stored word is 0x0000 (0x2000 in the variant) and every strobe is high on every cycle.
- R12: A request with a domain index above 5 returns rsp_err = 1 and leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word (takes priority over a set request) |
| wr_data | input | 16 | Raw control word to be clamped and stored |
| req_valid | input | 1 | Rate request valid |
| req_round | input | 1 | 1: report only, 0: apply to the register |
| req_dom | input | 3 | Domain index of the request |
| req_master | input | RATE_W | Master clock rate |
| req_target | input | RATE_W | Requested domain rate |
| ctl_out | output | 16 | Stored, clamped control word |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Request rejected |
| rsp_exp | output | 2 | Chosen exponent |
| dom_en | output | 6 | Clock-enable strobes, bit order as the domain index |

## Verification
The hardest condition to create from the ports is an exponent change that lands while the shared counter is in the middle of a period. In that case the old ratio must stay in force until the wrap. The stimulus first gives the peripheral domain a ratio of 8 and waits for its strobe, which marks counter phase 0. It then writes ratio 1 on the next cycle and checks that the strobe stays low for the rest of the period before it goes high every cycle. Unreachable set requests are driven at exact boundaries, one below master/8, so that an off-by-one in the exponent search shows up as a changed register.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int NDOM  = 6;
    localparam int EXPW  = 2;
    localparam int CTLW  = 16;
    localparam int CNTW  = 3;
    localparam int MAXEXP = (1 << EXPW) - 1;

    typedef enum logic [2:0] {
        DOM_PER = 3'd0,
        DOM_LCD = 3'd1,
        DOM_CPU = 3'd2,
        DOM_DSP = 3'd3,
        DOM_TC  = 3'd4,
        DOM_MMU = 3'd5
    } dom_e;
endpackage

// File: rtl/ckctl_sanitize.sv
module ckctl_sanitize
    import clkdiv_pkg::*;
#(
    parameter bit FORCE_B13 = 1'b0
) (
    input  logic [CTLW-1:0] raw,
    output logic [CTLW-1:0] clean
);
    logic [EXPW:0] per_x, lcd_x, cpu_x, dsp_x, tc_x, mmu_x;

    always_comb begin
        per_x = {1'b0, raw[1:0]};
        lcd_x = {1'b0, raw[3:2]};
        cpu_x = {1'b0, raw[5:4]};
        dsp_x = {1'b0, raw[7:6]};
        tc_x  = {1'b0, raw[9:8]};
        mmu_x = {1'b0, raw[11:10]};
        // fixed order: mmu window, tc floor, then the slow domains
        if (mmu_x < dsp_x)         mmu_x = dsp_x;
        if (mmu_x > dsp_x + 3'd1)  mmu_x = dsp_x + 3'd1;
        if (tc_x < cpu_x)          tc_x  = cpu_x;
        if (tc_x < mmu_x)          tc_x  = mmu_x;
        if (lcd_x < tc_x)          lcd_x = tc_x;
        if (per_x < tc_x)          per_x = tc_x;
        clean = {raw[15:12], mmu_x[1:0], tc_x[1:0], dsp_x[1:0],
                 cpu_x[1:0], lcd_x[1:0], per_x[1:0]};
        if (FORCE_B13) clean[13] = 1'b1;
    end
endmodule

// File: rtl/rate_exp_calc.sv
module rate_exp_calc
    import clkdiv_pkg::*;
#(
    parameter int RATE_W = 32
) (
    input  logic [RATE_W-1:0] master,
    input  logic [RATE_W-1:0] target,
    output logic              reach,
    output logic [EXPW-1:0]   exp_o
);
    localparam int NSTEP = MAXEXP + 1;
    logic [NSTEP-1:0] hit;

    for (genvar e = 0; e < NSTEP; e++) begin : g_step
        assign hit[e] = (master >> e) <= target;
    end

    always_comb begin
        reach = |hit;
        exp_o = EXPW'(MAXEXP);
        for (int e = NSTEP - 1; e >= 0; e--) begin
            if (hit[e]) exp_o = EXPW'(e);
        end
    end
endmodule

// File: rtl/domain_strobe.sv
module domain_strobe
    import clkdiv_pkg::*;
(
    input  logic [CNTW-1:0] cnt,
    input  logic [EXPW-1:0] exp_i,
    output logic            en
);
    logic [CNTW-1:0] mask;

    always_comb begin
        mask = (CNTW'(1) << exp_i) - CNTW'(1);
        en   = (cnt & mask) == '0;
    end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int RATE_W    = 32,
    parameter bit FORCE_B13 = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    input  logic              req_valid,
    input  logic              req_round,
    input  logic [2:0]        req_dom,
    input  logic [RATE_W-1:0] req_master,
    input  logic [RATE_W-1:0] req_target,
    output logic [15:0]       ctl_out,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [1:0]        rsp_exp,
    output logic [5:0]        dom_en
);
    localparam logic [CTLW-1:0] RST_CTL = FORCE_B13 ? 16'h2000 : 16'h0000;

    typedef struct packed {
        logic [CTLW-1:0]            ctl;
        logic [CNTW-1:0]            cnt;
        logic [NDOM-1:0][EXPW-1:0]  act;
        logic                       rsp_valid;
        logic                       rsp_err;
        logic [EXPW-1:0]            rsp_exp;
    } state_t;

    state_t st_d, st_q;

    logic            reach;
    logic [EXPW-1:0] calc_exp;
    logic            dom_ok;
    logic            set_ok;
    logic [CTLW-1:0] merged;
    logic [CTLW-1:0] san_in;
    logic [CTLW-1:0] san_out;

    rate_exp_calc #(.RATE_W(RATE_W)) u_calc (
        .master (req_master),
        .target (req_target),
        .reach  (reach),
        .exp_o  (calc_exp)
    );

    ckctl_sanitize #(.FORCE_B13(FORCE_B13)) u_san (
        .raw   (san_in),
        .clean (san_out)
    );

    for (genvar i = 0; i < NDOM; i++) begin : g_dom
        domain_strobe u_stb (
            .cnt   (st_q.cnt),
            .exp_i (st_q.act[i]),
            .en    (dom_en[i])
        );
    end

    always_comb begin
        st_d   = st_q;
        dom_ok = req_dom < 3'(NDOM);
        set_ok = req_valid && !req_round && dom_ok && reach;
        merged = st_q.ctl;
        if (dom_ok) merged[{req_dom, 1'b0} +: EXPW] = calc_exp;
        san_in = wr_en ? wr_data : merged;

        if (wr_en || set_ok) st_d.ctl = san_out;

        st_d.cnt = st_q.cnt + CNTW'(1);
        if (st_q.cnt == '1) begin
            for (int i = 0; i < NDOM; i++) st_d.act[i] = st_q.ctl[2*i +: EXPW];
        end

        st_d.rsp_valid = req_valid;
        st_d.rsp_err   = req_valid && (!dom_ok || (!req_round && !reach));
        st_d.rsp_exp   = reach ? calc_exp : EXPW'(MAXEXP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctl       <= RST_CTL;
            st_q.cnt       <= '0;
            st_q.act       <= '0;
            st_q.rsp_valid <= 1'b0;
            st_q.rsp_err   <= 1'b0;
            st_q.rsp_exp   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_out   = st_q.ctl;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_exp   = st_q.rsp_exp;

    // ordering invariants of the stored word
    assert_mmu_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_out[11:10] >= ctl_out[7:6]) &&
        ({1'b0, ctl_out[11:10]} <= {1'b0, ctl_out[7:6]} + 3'd1));
    assert_tc_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_out[9:8] >= ctl_out[5:4]) && (ctl_out[9:8] >= ctl_out[11:10]));
    assert_slow_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_out[3:2] >= ctl_out[9:8]) && (ctl_out[1:0] >= ctl_out[9:8]));
    assert_bit13_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !FORCE_B13 || ctl_out[13]);
    assert_reject_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_round && !reach && !wr_en) |=> ($stable(ctl_out) && rsp_err));
    assert_round_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_round && !wr_en) |=> $stable(ctl_out));
    assert_wrap_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |-> $stable(st_q.act));
    assert_phase_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dom_en[DOM_LCD] |-> dom_en[DOM_TC]);
endmodule

// File: tb/clkdiv_bank_tb.sv
module clkdiv_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_round = 1'b0;
    logic [2:0]  req_dom = '0;
    logic [31:0] req_master = '0;
    logic [31:0] req_target = '0;
    logic [15:0] ctl_out, v_ctl;
    logic        rsp_valid, rsp_err, v_valid, v_err;
    logic [1:0]  rsp_exp, v_exp;
    logic [5:0]  dom_en, v_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] m_ctl, m_vctl;

    always #10 clk = ~clk;

    clkdiv_bank #(.RATE_W(32), .FORCE_B13(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .req_valid(req_valid), .req_round(req_round), .req_dom(req_dom),
        .req_master(req_master), .req_target(req_target), .ctl_out(ctl_out),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_exp(rsp_exp), .dom_en(dom_en));

    clkdiv_bank #(.RATE_W(32), .FORCE_B13(1'b1)) u_dut_v (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .req_valid(req_valid), .req_round(req_round), .req_dom(req_dom),
        .req_master(req_master), .req_target(req_target), .ctl_out(v_ctl),
        .rsp_valid(v_valid), .rsp_err(v_err), .rsp_exp(v_exp), .dom_en(v_en));

    function automatic logic [15:0] clamp_word(logic [15:0] w, bit force13);
        int per, lcd, cpu, dsp, tc, mmu;
        logic [15:0] r;
        per = w[1:0]; lcd = w[3:2]; cpu = w[5:4];
        dsp = w[7:6]; tc = w[9:8]; mmu = w[11:10];
        if (mmu < dsp) mmu = dsp;
        if (mmu > dsp + 1) mmu = dsp + 1;
        if (tc < cpu) tc = cpu;
        if (tc < mmu) tc = mmu;
        if (lcd < tc) lcd = tc;
        if (per < tc) per = tc;
        r = {w[15:12], 2'(mmu), 2'(tc), 2'(dsp), 2'(cpu), 2'(lcd), 2'(per)};
        if (force13) r[13] = 1'b1;
        return r;
    endfunction

    function automatic int pick_exp(logic [31:0] m, logic [31:0] t);
        for (int e = 0; e < 4; e++) if ((m >> e) <= t) return e;
        return 4;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [15:0] w);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        m_ctl  = clamp_word(w, 1'b0);
        m_vctl = clamp_word(w, 1'b1);
        check("R2 R3 R4 R5 write", ctl_out, m_ctl);
        check("R6 variant write", v_ctl, m_vctl);
    endtask

    task automatic do_req(bit rnd, logic [2:0] d, logic [31:0] m, logic [31:0] t);
        int e;
        bit err;
        logic [15:0] nw;
        e = pick_exp(m, t);
        err = (d > 5) || (!rnd && e == 4);
        req_valid = 1'b1; req_round = rnd; req_dom = d; req_master = m; req_target = t;
        @(negedge clk);
        req_valid = 1'b0;
        if (!err && !rnd) begin
            nw = m_ctl;  nw[2*d +: 2] = 2'(e); m_ctl  = clamp_word(nw, 1'b0);
            nw = m_vctl; nw[2*d +: 2] = 2'(e); m_vctl = clamp_word(nw, 1'b1);
        end
        check("R7 rsp_valid", rsp_valid, 1);
        check(d > 5 ? "R12 bad domain err" : (rnd ? "R9 round err" : "R8 set err"), rsp_err, err);
        if (d <= 5) check(rnd ? "R9 round exp" : "R7 exp", rsp_exp, (e == 4) ? 3 : e);
        check(rnd ? "R9 register kept" : (err ? "R8 R12 register kept" : "R7 register"), ctl_out, m_ctl);
        check("R6 variant after request", v_ctl, m_vctl);
    endtask

    task automatic check_rates();
        int cnt [6];
        repeat (16) @(negedge clk);
        for (int i = 0; i < 6; i++) cnt[i] = 0;
        repeat (16) begin
            @(negedge clk);
            for (int i = 0; i < 6; i++) if (dom_en[i]) cnt[i]++;
        end
        for (int i = 0; i < 6; i++) check("R1 strobe count", cnt[i], 16 >> m_ctl[2*i +: 2]);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] m, t;
        int wait_cyc;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ctl = 16'h0000; m_vctl = 16'h2000;
        @(negedge clk);
        // R11 reset state
        check("R11 reset word", ctl_out, 16'h0000);
        check("R11 variant reset word", v_ctl, 16'h2000);
        repeat (3) begin
            check("R11 strobes after reset", dom_en, 6'h3f);
            @(negedge clk);
        end

        // directed clamp corners
        do_write(16'hF0C0);          // dsp 3, mmu 0 -> mmu 3, tc 3, lcd/per 3
        do_write(16'h0C00);          // mmu 3 above dsp+1 -> mmu 1
        do_write(16'h0030);          // cpu 3 raises tc, then lcd/per
        do_write(16'hA5FF);          // top nibble kept
        do_write(16'h0000);
        check_rates();
        do_write(16'h0E59);
        check_rates();

        // R10: exponent change mid period waits for wrap
        do_write(16'h0003);          // peripheral ratio 8
        repeat (16) @(negedge clk);
        wait_cyc = 0;
        while (!dom_en[0] && wait_cyc < 16) begin
            @(negedge clk);
            wait_cyc++;
        end
        check("R10 found phase", dom_en[0], 1);
        do_write(16'h0000);          // counter now at 1
        check("R10 old ratio kept", dom_en[0], 0);
        repeat (6) begin
            @(negedge clk);
            check("R10 old ratio kept", dom_en[0], 0);
        end
        repeat (8) begin
            @(negedge clk);
            check("R10 new ratio after wrap", dom_en[0], 1);
        end

        // directed request corners
        m = 32'd96_000_000;
        do_req(1'b0, 3'd2, m, m);               // exp 0
        do_req(1'b0, 3'd2, m, (m >> 3));        // exp 3 exact boundary
        do_req(1'b0, 3'd0, m, (m >> 3) - 1);    // unreachable set
        do_req(1'b1, 3'd0, m, (m >> 3) - 1);    // round saturates
        do_req(1'b0, 3'd6, m, m);               // bad domain
        do_req(1'b1, 3'd7, m, m);
        do_req(1'b0, 3'd3, m, (m >> 1) + 5);    // dsp exp 1
        do_req(1'b0, 3'd0, 32'd0, 32'd0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 2) == 0) begin
                do_write(16'($urandom));
            end else begin
                m = $urandom_range(1000, 200_000_000);
                case ($urandom_range(0, 3))
                    0: t = m >> $urandom_range(0, 4);
                    1: t = (m >> $urandom_range(0, 3)) - 1;
                    2: t = $urandom_range(0, 300_000_000);
                    default: t = (m >> 3) - $urandom_range(0, 2);
                endcase
                do_req(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), m, t);
            end
            if (n % 100 == 99) check_rates();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule